// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Read-to-Write Turnaround

This block turns CPU-side transfer requests into external memory bus cycles. Each request carries a direction flag, an address and write data. The block drives the address, one active-low chip select per address area, an active-low read strobe, an active-low write strobe and the enable for the data-bus output drivers. A read occupies three bus states and a write occupies two. The request port uses a valid/ready handshake. The next request can be accepted in the final state of the current cycle, so cycles can run back to back.

A slow device can keep driving read data for a while after its read ends, and a lagging read strobe can still be low when the next chip select falls. To avoid both, a configuration bit lets the block put one turnaround state between a read and a write that follows it directly. No chip select, strobe or output enable is active in that state. The bit is set after reset, and a single-cycle configuration write changes it. The area is chosen by the two most significant address bits. When a read completes, the data is returned with a one-cycle completion pulse.

The states are BUS_IDLE, RD_T1, RD_T2, RD_T3, TURN, WR_T1 and WR_T2. The transitions are:
- BUS_IDLE to RD_T1 or WR_T1 on acceptance.
- RD_T1 to RD_T2 to RD_T3.
- RD_T3 to TURN (write accepted, turnaround enabled), WR_T1 (write accepted, turnaround disabled), RD_T1 (read accepted) or BUS_IDLE.
- TURN to WR_T1.
- WR_T1 to WR_T2.
- WR_T2 to RD_T1, WR_T1 or BUS_IDLE.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, every chip select, the read strobe and the write strobe are high, the output enable is low, the request port is ready and no completion pulse is present.
- R2: A read holds the selected chip select low and the read strobe low for exactly three consecutive cycles, with the write strobe high and the output enable low.
- R3: A write lasts two cycles with the selected chip select low in both. The output enable is high in both, with the write data on the data output. The write strobe is low only in the second cycle, and the read strobe stays high.
- R4: Address bits [ADDR_W-1:ADDR_W-2] pick the chip select: value n drives bit n of the chip select vector low, and at most one chip select is low at any time.
- R5: When turnaround is enabled and a write is accepted in a read's third cycle, exactly one cycle follows in which all chip selects and both strobes are high, the output enable is low and ready is low. The write's first cycle comes after that cycle.
- R6: When turnaround is disabled, a write accepted in a read's third cycle starts its first cycle in the very next cycle.
- R7: The turnaround enable is 1 after reset.
- R8: No turnaround cycle appears for write after write, read after write or read after read, or when at least one bus-idle cycle lies between a read and a write.
- R9: Ready is high only when the bus is idle, in a read's third cycle or in a write's second cycle. A request is taken on a clock edge where valid and ready are both high.
- R10: The completion pulse is high for exactly one cycle, in the cycle after the last state of every transfer. For a read, the data-input value present in the third cycle is returned with that pulse.
- R11: A configuration write (cfg_we high at a clock edge) loads cfg_idle_en into the turnaround enable. The new value applies to every read-then-write decision made afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the turnaround enable |
| cfg_idle_en | input | 1 | New turnaround enable value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_done | output | 1 | One-cycle transfer completion pulse |
| rsp_rdata | output | DATA_W | Data returned by the last read |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | NUM_AREAS | Active-low chip selects, one per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_doe | output | 1 | Data-bus output enable |
| bus_dout | output | DATA_W | Data driven during writes |
| bus_din | input | DATA_W | Data sampled during reads |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit data and four areas. With these, random upper address bits reach every chip select, and the read data can be derived from the address low byte. Random gaps of zero to two cycles between requests produce both back-to-back pairs and pairs separated by idle cycles, for every read/write ordering. The same random traffic runs with the turnaround enabled, then disabled, then enabled again, so both branches of the read-then-write decision are exercised.

// File: rtl/ext_bus_pkg.sv
`timescale 1ns/1ps
package ext_bus_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE,
        RD_T1,
        RD_T2,
        RD_T3,
        TURN,
        WR_T1,
        WR_T2
    } bus_state_e;

endpackage

// File: rtl/ebs_cfg.sv
`timescale 1ns/1ps
module ebs_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_idle_en,
    output logic idle_en
);
    logic en_q;

    // Turnaround insertion is on out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b1;
        else if (cfg_we)
            en_q <= cfg_idle_en;
    end

    assign idle_en = en_q;
endmodule

// File: rtl/ebs_area_dec.sv
`timescale 1ns/1ps
module ebs_area_dec #(
    parameter int ADDR_W    = 16,
    parameter int NUM_AREAS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 active,
    output logic [NUM_AREAS-1:0] cs_n
);
    localparam int SEL_W = $clog2(NUM_AREAS);

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1 -: SEL_W];

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        assign cs_n[g] = !(active && (sel == SEL_W'(g)));
    end
endmodule

// File: rtl/ebs_fsm.sv
`timescale 1ns/1ps
module ebs_fsm
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              cyc_active,
    output logic              rd_n,
    output logic              wr_n,
    output logic              doe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    bus_state_e state_q, state_d;
    logic       take;
    logic       done_q;
    logic [DATA_W-1:0] rdata_q;

    assign take = req_valid && req_ready;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = req_write ? WR_T1 : RD_T1;
            RD_T1:    state_d = RD_T2;
            RD_T2:    state_d = RD_T3;
            RD_T3: begin
                if (!req_valid)     state_d = BUS_IDLE;
                else if (!req_write) state_d = RD_T1;
                else                 state_d = idle_en ? TURN : WR_T1;
            end
            TURN:     state_d = WR_T1;
            WR_T1:    state_d = WR_T2;
            WR_T2: begin
                if (!req_valid)     state_d = BUS_IDLE;
                else                 state_d = req_write ? WR_T1 : RD_T1;
            end
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            done_q <= (state_q == RD_T3) || (state_q == WR_T2);
            if (state_q == RD_T3)
                rdata_q <= bus_din;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        cyc_active = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        doe        = 1'b0;
        unique case (state_q)
            BUS_IDLE: req_ready = 1'b1;
            RD_T1, RD_T2: begin
                cyc_active = 1'b1;
                rd_n       = 1'b0;
            end
            RD_T3: begin
                cyc_active = 1'b1;
                rd_n       = 1'b0;
                req_ready  = 1'b1;
            end
            TURN: ;
            WR_T1: begin
                cyc_active = 1'b1;
                doe        = 1'b1;
            end
            WR_T2: begin
                cyc_active = 1'b1;
                doe        = 1'b1;
                wr_n       = 1'b0;
                req_ready  = 1'b1;
            end
            default: ;
        endcase
    end

    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int NUM_AREAS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_idle_en,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_AREAS-1:0] bus_cs_n,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic                 bus_doe,
    output logic [DATA_W-1:0]    bus_dout,
    input  logic [DATA_W-1:0]    bus_din
);
    logic idle_en_q;
    logic cyc_active;

    ebs_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_idle_en (cfg_idle_en),
        .idle_en     (idle_en_q)
    );

    ebs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_en    (idle_en_q),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .bus_din    (bus_din),
        .addr_q     (bus_addr),
        .wdata_q    (bus_dout),
        .cyc_active (cyc_active),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .doe        (bus_doe),
        .done       (rsp_done),
        .rdata      (rsp_rdata)
    );

    ebs_area_dec #(.ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS)) u_dec (
        .addr   (bus_addr),
        .active (cyc_active),
        .cs_n   (bus_cs_n)
    );
endmodule

// File: rtl/ext_bus_seq_chk.sv
`timescale 1ns/1ps
module ext_bus_seq_chk #(
    parameter int NUM_AREAS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 idle_en,
    input logic [NUM_AREAS-1:0] cs_n,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 doe,
    input logic                 done
);
    // R4
    cs_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3
    wr_needs_doe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> doe);

    // R3
    doe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> (cs_n != '1));

    // R5
    turn_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && idle_en) |=> !doe);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_en (idle_en_q),
    .cs_n    (bus_cs_n),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .doe     (bus_doe),
    .done    (rsp_done)
);

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;
    localparam int AW   = 16;
    localparam int DW   = 8;
    localparam int NA   = 4;
    localparam int LOGN = 4096;
    localparam int MAXR = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_idle_en = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done, bus_rd_n, bus_wr_n, bus_doe;
    logic [DW-1:0] rsp_rdata, bus_dout, bus_din;
    logic [AW-1:0] bus_addr;
    logic [NA-1:0] bus_cs_n;

    ext_bus_seq #(.ADDR_W(AW), .DATA_W(DW), .NUM_AREAS(NA)) u_ext_bus_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idle_en(cfg_idle_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_doe(bus_doe),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    always #5 clk = ~clk;

    // device model: read data derived from the address
    assign bus_din = bus_addr[DW-1:0] ^ 8'h5A;

    int checks = 0, errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    logic [7:0]    l_sig   [LOGN];
    logic [DW-1:0] l_dout  [LOGN];
    logic          l_done  [LOGN];
    logic [DW-1:0] l_rdata [LOGN];

    int            r_acc   [MAXR];
    bit            r_wr    [MAXR];
    logic [AW-1:0] r_addr  [MAXR];
    logic [DW-1:0] r_wdata [MAXR];
    bit            r_en    [MAXR];
    int nreq = 0;
    bit cur_en = 1'b1;

    function automatic logic [7:0] sig(logic [3:0] cs, logic rd, logic wr, logic oe, logic rdy);
        return {cs, rd, wr, oe, rdy};
    endfunction

    function automatic logic [3:0] cs_for(logic [AW-1:0] a);
        return ~(4'b0001 << a[AW-1 -: 2]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && cyc < LOGN) begin
            l_sig[cyc]   <= sig(bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, req_ready);
            l_dout[cyc]  <= bus_dout;
            l_done[cyc]  <= rsp_done;
            l_rdata[cyc] <= rsp_rdata;
            if (rsp_done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic send(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
        if (gap > 0) begin
            req_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (nreq < MAXR) begin
            r_acc[nreq]   = cyc;
            r_wr[nreq]    = w;
            r_addr[nreq]  = a;
            r_wdata[nreq] = d;
            r_en[nreq]    = cur_en;
            nreq++;
        end
        @(negedge clk);
    endtask

    task automatic set_en(input bit v);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        cfg_we = 1'b1;
        cfg_idle_en = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_en = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic random_burst(input int n);
        for (int k = 0; k < n; k++) begin
            bit w = $urandom % 2;
            logic [AW-1:0] a = AW'($urandom);
            logic [DW-1:0] d = DW'($urandom);
            int gap = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
            send(w, a, d, gap);
        end
    endtask

    task automatic verify_all();
        int prev_end = -1;
        bit prev_wr  = 1'b1;
        for (int i = 0; i < nreq; i++) begin
            int start = r_acc[i] + 1;
            bit b2b   = (i > 0) && (r_acc[i] == prev_end);
            string tg;
            logic [3:0] cs = cs_for(r_addr[i]);
            if (b2b && !prev_wr && r_wr[i]) tg = r_en[i] ? "R5" : "R6 R11";
            else if (b2b)                   tg = "R8";
            else                            tg = "R8 idle-gap";
            if (i == 1) tg = {tg, " R7"};
            // bus idle between separated transfers
            if (i > 0) begin
                for (int c = prev_end + 1; c < start; c++)
                    if (c < LOGN) chk("R9 bus idle", 32'(l_sig[c]), 32'(sig(4'hF, 1, 1, 0, 1)));
            end
            if (b2b && !prev_wr && r_wr[i] && r_en[i]) begin
                chk("R5 turnaround", 32'(l_sig[start]), 32'(sig(4'hF, 1, 1, 0, 0)));
                start++;
            end
            if (start + 4 >= LOGN) begin
                chk("R9 log range", 32'(start), 32'(0));
                break;
            end
            if (!r_wr[i]) begin
                for (int k = 0; k < 3; k++)
                    chk({"R2 R4 R9 read ", tg}, 32'(l_sig[start+k]),
                        32'(sig(cs, 0, 1, 0, (k == 2))));
                prev_end = start + 2;
                chk("R10 read done", 32'(l_done[prev_end+1]), 32'(1));
                chk("R10 read data", 32'(l_rdata[prev_end+1]), 32'(r_addr[i][DW-1:0] ^ 8'h5A));
            end else begin
                for (int k = 0; k < 2; k++) begin
                    chk({"R3 R4 R9 write ", tg}, 32'(l_sig[start+k]),
                        32'(sig(cs, 1, (k == 0), 1, (k == 1))));
                    chk("R3 write data", 32'(l_dout[start+k]), 32'(r_wdata[i]));
                end
                prev_end = start + 1;
                chk("R10 write done", 32'(l_done[prev_end+1]), 32'(1));
            end
            prev_wr = r_wr[i];
        end
        chk("R10 pulse count", 32'(done_cnt), 32'(nreq));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset bus", 32'(sig(bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, req_ready)),
            32'(sig(4'hF, 1, 1, 0, 1)));
        chk("R1 reset done", 32'(rsp_done), 32'(0));
        // R7 / R5: default enable, read then write back to back
        send(1'b0, 16'h4012, 8'h00, 0);
        send(1'b1, 16'h4013, 8'hA5, 0);
        // R4: every area, and R8 orderings
        send(1'b1, 16'h0001, 8'h11, 0);
        send(1'b1, 16'h8002, 8'h22, 0);
        send(1'b0, 16'hC003, 8'h00, 0);
        send(1'b0, 16'h0004, 8'h00, 0);
        send(1'b1, 16'h4005, 8'h33, 1);
        send(1'b0, 16'hC006, 8'h00, 0);
        send(1'b1, 16'h8007, 8'h44, 2);
        random_burst(100);
        // R11 / R6: disable turnaround
        set_en(1'b0);
        send(1'b0, 16'h8100, 8'h00, 0);
        send(1'b1, 16'h8101, 8'h55, 0);
        random_burst(90);
        set_en(1'b1);
        random_burst(50);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        verify_all();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule